// File: doc/BRIEF.md
# Partitioned Packed Integer Subtractor

This block subtracts two 64-bit operands as a vector of independent integer elements. A request carries an operation code, a minuend operand and a subtrahend operand. The code selects one of three element sizes: 8, 16 or 32 bits. Every element of the result is the minuend element minus the subtrahend element, reduced modulo two to the element width. The borrow out of an element is dropped, and the result wraps instead of clamping.

A single ripple chain of byte segments does all the arithmetic. The boundaries between segments are either cut or joined at run time, depending on the decoded element size. Element 0 sits in the least significant bits, and higher elements follow in ascending bit order.

Requests are accepted on every clock cycle. The result, its valid strobe and an illegal-code flag are registered and appear one clock after the request. An unrecognised code returns a flagged, all-zero result.

Top module: `packed_sub_unit`

## Requirements
- R1: With code 0xF8, each of the eight 8-bit elements of out_data (element i at bits [8i+7:8i]) equals in_a element minus in_b element, modulo 256.
- R2: With code 0xF9, each of the four 16-bit elements (element i at bits [16i+15:16i]) equals the in_a element minus the in_b element, modulo 65536.
- R3: With code 0xFA, each of the two 32-bit elements (element i at bits [32i+31:32i]) equals the in_a element minus the in_b element, modulo 2^32.
- R4: No borrow crosses an element boundary. For example, in byte mode, 0x00 minus 0x01 gives 0xFF in that element and leaves the element above it unchanged. In doubleword mode, a low element of 0 minus 1 gives 0xFFFFFFFF while an upper element of 0 minus 0 stays 0.
- R5: Element 0 occupies the lowest bits. Distinct values placed in each element come back in the same positions.
- R6: In word mode, 0x8000 minus 0x0001 gives 0x7FFF, and 0x7F38 minus 0xE8F9 gives 0x963F.
- R7: Any code other than 0xF8, 0xF9 or 0xFA sets out_illegal together with out_valid, and out_data is all zeros.
- R8: out_valid is high exactly one clock after in_valid was high and low one clock after it was low. Back-to-back requests on consecutive cycles each produce their own result.
- R9: A synchronous active-high rst clears out_valid and out_illegal at the next clock edge, even if a request is present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_opcode | input | 8 | Operation code selecting the element size |
| in_a | input | 64 | Minuend operand |
| in_b | input | 64 | Subtrahend operand |
| out_valid | output | 1 | Result strobe, one clock after the request |
| out_illegal | output | 1 | Request carried an unrecognised code |
| out_data | output | 64 | Packed difference, or zero when the code is illegal |

## Verification
The hardest case is a borrow generated in one element while the element above it would propagate a borrow if the boundary were joined. The bench reaches it by sweeping every pair of byte values across all eight byte elements at once, with a different offset per element, so every boundary sees every borrow and propagate combination. The same boundaries are then exercised in word and doubleword modes with patterns whose low halves underflow. An error in the cut mask shows up as an off-by-one in the neighbouring element.

// File: rtl/psub_pkg.sv
package psub_pkg;

   typedef enum logic [1:0] {
      LM_BYTE  = 2'd0,
      LM_WORD  = 2'd1,
      LM_DWORD = 2'd2,
      LM_NONE  = 2'd3
   } lane_mode_e;

   // Number of byte segments forming one element in a given mode
   function automatic int segs_per_lane(lane_mode_e m);
      case (m)
         LM_BYTE:  return 1;
         LM_WORD:  return 2;
         LM_DWORD: return 4;
         default:  return 1;
      endcase
   endfunction

endpackage

// File: rtl/psub_decode.sv
module psub_decode
   import psub_pkg::*;
#(
   parameter logic [7:0] OPC_BYTE  = 8'hF8,
   parameter logic [7:0] OPC_WORD  = 8'hF9,
   parameter logic [7:0] OPC_DWORD = 8'hFA
) (
   input  logic [7:0]  opcode,
   output lane_mode_e  mode,
   output logic        bad
);

   initial begin
      assert (OPC_BYTE != OPC_WORD && OPC_WORD != OPC_DWORD && OPC_BYTE != OPC_DWORD)
         else $fatal(1, "psub_decode: operation codes must differ");
   end

   always_comb begin
      if (opcode == OPC_BYTE)       mode = LM_BYTE;
      else if (opcode == OPC_WORD)  mode = LM_WORD;
      else if (opcode == OPC_DWORD) mode = LM_DWORD;
      else                          mode = LM_NONE;
   end

   assign bad = (opcode != OPC_BYTE) && (opcode != OPC_WORD) && (opcode != OPC_DWORD);

endmodule

// File: rtl/psub_cut_gen.sv
module psub_cut_gen
   import psub_pkg::*;
#(
   parameter int NSEG = 8
) (
   input  lane_mode_e        mode,
   output logic [NSEG-1:0]   cut
);

   always_comb begin
      for (int s = 0; s < NSEG; s++) begin
         // a boundary is cut where a new element starts
         cut[s] = ((s % segs_per_lane(mode)) == 0);
      end
   end

endmodule

// File: rtl/psub_chain.sv
module psub_chain #(
   parameter int DATA_W = 64,
   parameter int SEG_W  = 8,
   localparam int NSEG  = DATA_W / SEG_W
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [NSEG-1:0]   cut,
   output logic [DATA_W-1:0] diff
);

   initial begin
      assert (DATA_W % SEG_W == 0 && NSEG >= 2)
         else $fatal(1, "psub_chain: DATA_W must hold at least two segments");
   end

   logic [NSEG-2:0] seg_cout;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic cin;
      if (s == 0) begin : g_first
         assign cin = 1'b1;
      end else begin : g_link
         // a cut boundary restarts the two's-complement +1
         assign cin = cut[s] ? 1'b1 : seg_cout[s-1];
      end

      if (s < NSEG - 1) begin : g_mid
         logic [SEG_W:0] sum;
         assign sum = {1'b0, a[s*SEG_W +: SEG_W]} + {1'b0, ~b[s*SEG_W +: SEG_W]}
                      + {{SEG_W{1'b0}}, cin};
         assign diff[s*SEG_W +: SEG_W] = sum[SEG_W-1:0];
         assign seg_cout[s] = sum[SEG_W];
      end else begin : g_top
         assign diff[s*SEG_W +: SEG_W] = a[s*SEG_W +: SEG_W] + ~b[s*SEG_W +: SEG_W]
                                          + {{(SEG_W-1){1'b0}}, cin};
      end
   end

endmodule

// File: rtl/packed_sub_unit.sv
module packed_sub_unit
   import psub_pkg::*;
#(
   parameter int         DATA_W    = 64,
   parameter int         SEG_W     = 8,
   parameter logic [7:0] OPC_BYTE  = 8'hF8,
   parameter logic [7:0] OPC_WORD  = 8'hF9,
   parameter logic [7:0] OPC_DWORD = 8'hFA
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [7:0]        in_opcode,
   input  logic [63:0]       in_a,
   input  logic [63:0]       in_b,
   output logic              out_valid,
   output logic              out_illegal,
   output logic [63:0]       out_data
);

   localparam int NSEG   = DATA_W / SEG_W;
   localparam int DWORD  = 4 * SEG_W;

   initial begin
      assert (DATA_W == 64)
         else $fatal(1, "packed_sub_unit: port width is fixed at 64");
      assert (DATA_W % DWORD == 0)
         else $fatal(1, "packed_sub_unit: DATA_W must hold whole doubleword elements");
   end

   lane_mode_e        mode;
   logic              bad;
   logic [NSEG-1:0]   cut;
   logic [DATA_W-1:0] diff;

   psub_decode #(
      .OPC_BYTE  (OPC_BYTE),
      .OPC_WORD  (OPC_WORD),
      .OPC_DWORD (OPC_DWORD)
   ) u_decode (
      .opcode (in_opcode),
      .mode   (mode),
      .bad    (bad)
   );

   psub_cut_gen #(.NSEG(NSEG)) u_cut (
      .mode (mode),
      .cut  (cut)
   );

   psub_chain #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chain (
      .a    (in_a),
      .b    (in_b),
      .cut  (cut),
      .diff (diff)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_data    <= '0;
      end else begin
         out_valid   <= in_valid;
         out_illegal <= in_valid & bad;
         if (in_valid) out_data <= bad ? '0 : diff;
      end
   end

   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R8
   valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R7
   illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> (out_valid && out_data == '0));

   // R1
   byte_lane0_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_opcode == OPC_BYTE)
      |=> out_data[SEG_W-1:0] == SEG_W'($past(in_a[SEG_W-1:0]) - $past(in_b[SEG_W-1:0])));

   // R3
   dword_top_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_opcode == OPC_DWORD)
      |=> out_data[DATA_W-1 -: DWORD] ==
          DWORD'($past(in_a[DATA_W-1 -: DWORD]) - $past(in_b[DATA_W-1 -: DWORD])));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && !out_illegal));

endmodule

// File: tb/sim_packed_sub_unit.sv
`timescale 1ns/1ps
module sim_packed_sub_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_opcode = 8'h00;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic        out_valid;
   logic        out_illegal;
   logic [63:0] out_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // pending expectation for the request driven on the previous negedge
   logic        p_valid = 1'b0;
   logic        p_illegal = 1'b0;
   logic [63:0] p_data = '0;
   string       p_tag = "R9";

   always #2.5 clk = ~clk;

   packed_sub_unit u0 (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_opcode (in_opcode),
      .in_a (in_a), .in_b (in_b),
      .out_valid (out_valid), .out_illegal (out_illegal), .out_data (out_data)
   );

   function automatic logic [63:0] model(input logic [7:0] op, input logic [63:0] a,
                                         input logic [63:0] b);
      int w;
      logic [63:0] mask, r, t;
      if (op == 8'hF8) w = 8;
      else if (op == 8'hF9) w = 16;
      else if (op == 8'hFA) w = 32;
      else return 64'h0;
      mask = (64'h1 << w) - 64'h1;
      r = '0;
      for (int k = 0; k < 64; k += w) begin
         t = (((a >> k) & mask) - ((b >> k) & mask)) & mask;
         r = r | (t << k);
      end
      return r;
   endfunction

   task automatic compare();
      checks++;
      if (out_valid !== p_valid || out_illegal !== p_illegal ||
          (p_valid && out_data !== p_data)) begin
         errors++;
         $display("FAIL %s: got v=%b ill=%b data=%h, expected v=%b ill=%b data=%h",
                  p_tag, out_valid, out_illegal, out_data, p_valid, p_illegal, p_data);
      end
   endtask

   task automatic send(input logic v, input logic [7:0] op, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
      logic legal;
      @(negedge clk);
      compare();
      legal = (op == 8'hF8) || (op == 8'hF9) || (op == 8'hFA);
      in_valid = v; in_opcode = op; in_a = a; in_b = b;
      p_valid = v; p_illegal = v && !legal; p_data = model(op, a, b); p_tag = tag;
   endtask

   task automatic fixed(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] want, input string tag);
      send(1'b1, op, a, b, tag);
      @(negedge clk);
      compare();
      checks++;
      if (out_data !== want) begin
         errors++;
         $display("FAIL %s: got data=%h, expected %h", tag, out_data, want);
      end
      in_valid = 1'b0; p_valid = 1'b0; p_illegal = 1'b0; p_tag = "R8";
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      checks++;
      if (out_valid !== 1'b0 || out_illegal !== 1'b0) begin
         errors++;
         $display("FAIL R9: got v=%b ill=%b, expected 0 0", out_valid, out_illegal);
      end
      rst = 1'b0;
      p_valid = 1'b0; p_illegal = 1'b0; p_tag = "R8";

      // R6 word examples from the requirement
      fixed(8'hF9, 64'h0000_0000_7F38_8000, 64'h0000_0000_E8F9_0001,
            64'h0000_0000_963F_7FFF, "R6");
      // R4 byte borrow isolation: 0x00-0x01 in one element, neighbours untouched
      fixed(8'hF8, 64'h5555_5555_5555_5500, 64'h0000_0000_0000_0001,
            64'h5555_5555_5555_55FF, "R4");
      // R4 doubleword isolation
      fixed(8'hFA, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001,
            64'h0000_0000_FFFF_FFFF, "R4");
      // R5 element order
      fixed(8'hF8, 64'h8877_6655_4433_2211, 64'h0706_0504_0302_0100,
            64'h8171_6151_4131_2111, "R5");
      fixed(8'hF9, 64'h4444_3333_2222_1111, 64'h0003_0002_0001_0000,
            64'h4441_3331_2221_1111, "R5");

      // R1 exhaustive byte sweep, all eight elements, back-to-back (R8)
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            logic [63:0] a, b;
            for (int i = 0; i < 8; i++) begin
               a[8*i +: 8] = 8'(x + 37 * i);
               b[8*i +: 8] = 8'(y + 91 * i);
            end
            send(1'b1, 8'hF8, a, b, "R1");
         end
      end

      // R2 word patterns, with idle gaps (R8)
      for (int n = 0; n < 3000; n++) begin
         logic [63:0] a, b;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         if (n % 4 == 0) b[15:0] = a[15:0] + 16'h1;
         send(1'b1, 8'hF9, a, b, "R2");
         if (n % 7 == 0) send(1'b0, 8'hF9, a, b, "R8");
      end

      // R3 doubleword patterns
      for (int n = 0; n < 3000; n++) begin
         logic [63:0] a, b;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         if (n % 3 == 0) a[31:0] = 32'h0;
         send(1'b1, 8'hFA, a, b, "R3");
      end

      // R7 every code value, including the legal ones
      for (int op = 0; op < 256; op++) begin
         send(1'b1, 8'(op), {$urandom, $urandom}, {$urandom, $urandom}, "R7");
      end

      // R9 reset with a request in the same cycle
      send(1'b1, 8'h00, 64'h1, 64'h2, "R7");
      @(negedge clk);
      compare();
      rst = 1'b1; in_valid = 1'b1; in_opcode = 8'h13;
      p_valid = 1'b0; p_illegal = 1'b0; p_tag = "R9";
      send(1'b0, 8'hF8, 64'h0, 64'h0, "R9");
      rst = 1'b0;
      send(1'b0, 8'hF8, 64'h0, 64'h0, "R8");
      @(negedge clk);
      compare();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got no completion, expected end of run");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule